// File: doc/BRIEF.md
# Clock Output Routing and Status Selector

This block sits between the clock-synthesis core of a dual-channel clock generator and its output pads. It receives a fixed-phase full-rate clock, a phase-delayed clock from the adjustable delay line, the recovered line pulse from the feedback divider chain, the conditioned horizontal sync input, the divided oscillator reference, and two lock flags. All of these arrive as level waveforms sampled by the block's own fast clock. From them it forms the data and pad-enable values for five output channels and one status output.

The delayed-clock channel has two copies. The differential copy is the delayed clock itself. The single-ended copy goes through a power-of-two scaler. The fixed-phase channel carries either the full-rate clock or a half-rate copy of the delayed clock whose edges follow the delayed clock's rising edges. A line-timing output shows either the recovered pulse or the external sync. The status output shows nothing, one of the two lock flags, or a reference waveform.

Every output is registered once, so a change at an input appears at the outputs exactly one clock later. A pulse on the delay-reset strobe clears both dividers, which gives a known output phase afterwards.

Top module: `clk_route_mux`

## Requirements
- R1: When `stat_en_i` is 2'b00, `lockref_o` is 0.
- R2: `stat_en_i` bit 1 enables DPA lock status and bit 0 enables PLL lock status. With only bit 1 set, `lockref_o` follows `dpa_lock_i`. With only bit 0 set, it follows `pll_lock_i`.
- R3: When `stat_en_i` is 2'b11, `lockref_o` follows `hsync_i ^ ref_pol_i` if `in_sel_i` is 0, and follows `osc_ref_i` if `in_sel_i` is 1.
- R4: `scale_i` codes 0, 1, 2 and 3 divide the delayed clock by 1, 2, 4 and 8 on `sdpa_o`. For codes other than 0, the output equals bit (code-1) of the count of `dly_clk_i` rising edges since the last clear, so it changes only on a rising edge of the delayed clock.
- R5: When `clk_src_i` is 1, `pclk_o` and `sclk_o` carry `fix_clk_i`. When it is 0, they carry a half-rate copy of `dly_clk_i`. That copy toggles on each rising edge of `dly_clk_i`.
- R6: `func_o` carries `line_pulse_i` when `func_sel_i` is 0 and `hsync_i` when it is 1.
- R7: `oe_en_i` holds the enable bits: bit 0 for PECL DPACLK, bit 1 for SSTL DPACLK, bit 2 for PECL CLK, bit 3 for SSTL CLK and bit 4 for FUNC. A 0 bit drives the matching `*_oe_o` low, which means high-Z at the pad, and forces that output's data to 0.
- R8: During reset, all five `*_oe_o` outputs are 1 and all data outputs are 0.
- R9: In the cycle after `dpa_rst_i` is high, `sdpa_o` and the half-rate CLK copy are 0. Both divider counts restart from zero.
- R10: `pdpa_o` carries `dly_clk_i` undivided.
- R11: Every output reflects the inputs of the previous clock cycle, with one register of latency on every path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fix_clk_i | input | 1 | Fixed-phase full-rate clock waveform |
| dly_clk_i | input | 1 | Phase-delayed clock waveform |
| line_pulse_i | input | 1 | Recovered line pulse from divider chain |
| hsync_i | input | 1 | Conditioned external sync |
| osc_ref_i | input | 1 | Divided oscillator reference |
| dpa_lock_i | input | 1 | Delay-line lock flag |
| pll_lock_i | input | 1 | PLL lock flag |
| dpa_rst_i | input | 1 | Delay reset strobe, clears dividers |
| oe_en_i | input | 5 | Output enables (see R7) |
| clk_src_i | input | 1 | 1 full-rate fixed clock, 0 half-rate delayed |
| func_sel_i | input | 1 | 0 line pulse, 1 external sync |
| stat_en_i | input | 2 | Status enables (bit1 DPA, bit0 PLL) |
| in_sel_i | input | 1 | Reference select for status in both-enabled mode |
| ref_pol_i | input | 1 | Sync polarity inversion |
| scale_i | input | SCALE_W | Single-ended DPACLK scaler code |
| pdpa_o | output | 1 | PECL DPACLK data |
| pdpa_oe_o | output | 1 | PECL DPACLK pad enable |
| sdpa_o | output | 1 | SSTL DPACLK data (scaled) |
| sdpa_oe_o | output | 1 | SSTL DPACLK pad enable |
| pclk_o | output | 1 | PECL CLK data |
| pclk_oe_o | output | 1 | PECL CLK pad enable |
| sclk_o | output | 1 | SSTL CLK data |
| sclk_oe_o | output | 1 | SSTL CLK pad enable |
| func_o | output | 1 | FUNC data |
| func_oe_o | output | 1 | FUNC pad enable |
| lockref_o | output | 1 | Multiplexed lock/reference status |

## Verification
The divider counts are the only hidden state. A wrong count appears on `sdpa_o` or on the half-rate CLK copy at the next rising edge of the delayed clock that should, or should not, move the selected count bit. For a divide-by-8 code, that can take up to four delayed-clock edges. A clear that fails to take effect shows on `sdpa_o` one cycle after the strobe, and it also shifts every later edge. For this reason the reference model tracks the edge count and compares against it on every cycle. The status, line-timing and enable paths hold no state, so an error in them shows one cycle after the input that exposes it.

// File: rtl/crm_pkg.sv
package crm_pkg;
   localparam int OE_N     = 5;
   localparam int OE_PDPA  = 0;
   localparam int OE_SDPA  = 1;
   localparam int OE_PCLK  = 2;
   localparam int OE_SCLK  = 3;
   localparam int OE_FUNC  = 4;

   // status enable pair: bit1 = delay-line lock, bit0 = PLL lock
   typedef enum logic [1:0] {
      ST_OFF = 2'b00,
      ST_PLL = 2'b01,
      ST_DPA = 2'b10,
      ST_REF = 2'b11
   } stat_mode_e;
endpackage

// File: rtl/crm_edge_div.sv
// Rising-edge counter divider; nxt_o is the value the output register takes.
module crm_edge_div #(
   parameter int CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_i,
   input  logic              clr_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              nxt_o
);
   localparam int MAX_CODE = (1 << CODE_W) - 1;
   localparam int CNT_W    = MAX_CODE;

   logic             prev_q;
   logic             rise;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             bit_sel;

   assign rise  = src_i & ~prev_q;
   assign cnt_d = cnt_q + CNT_W'(rise);

   always_comb begin
      bit_sel = src_i;
      for (int k = 1; k <= MAX_CODE; k++) begin
         if (code_i == CODE_W'(k)) bit_sel = cnt_d[k-1];
      end
   end

   assign nxt_o = clr_i ? 1'b0 : bit_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         prev_q <= src_i;
         cnt_q  <= clr_i ? '0 : cnt_d;
      end
   end
endmodule

// File: rtl/crm_status_sel.sv
module crm_status_sel
   import crm_pkg::*;
(
   input  logic [1:0] stat_en_i,
   input  logic       in_sel_i,
   input  logic       ref_pol_i,
   input  logic       hsync_i,
   input  logic       osc_ref_i,
   input  logic       dpa_lock_i,
   input  logic       pll_lock_i,
   output logic       nxt_o
);
   stat_mode_e mode;

   assign mode = stat_mode_e'(stat_en_i);

   always_comb begin
      unique case (mode)
         ST_OFF:  nxt_o = 1'b0;
         ST_DPA:  nxt_o = dpa_lock_i;
         ST_PLL:  nxt_o = pll_lock_i;
         ST_REF:  nxt_o = in_sel_i ? osc_ref_i : (hsync_i ^ ref_pol_i);
         default: nxt_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/clk_route_mux.sv
module clk_route_mux
   import crm_pkg::*;
#(
   parameter int SCALE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fix_clk_i,
   input  logic               dly_clk_i,
   input  logic               line_pulse_i,
   input  logic               hsync_i,
   input  logic               osc_ref_i,
   input  logic               dpa_lock_i,
   input  logic               pll_lock_i,
   input  logic               dpa_rst_i,
   input  logic [4:0]         oe_en_i,
   input  logic               clk_src_i,
   input  logic               func_sel_i,
   input  logic [1:0]         stat_en_i,
   input  logic               in_sel_i,
   input  logic               ref_pol_i,
   input  logic [SCALE_W-1:0] scale_i,
   output logic               pdpa_o,
   output logic               pdpa_oe_o,
   output logic               sdpa_o,
   output logic               sdpa_oe_o,
   output logic               pclk_o,
   output logic               pclk_oe_o,
   output logic               sclk_o,
   output logic               sclk_oe_o,
   output logic               func_o,
   output logic               func_oe_o,
   output logic               lockref_o
);
   if (SCALE_W < 1 || SCALE_W > 3) begin : g_bad_scale_w
      $error("clk_route_mux: SCALE_W must be 1 to 3");
   end

   logic            half_nxt;
   logic            scl_nxt;
   logic            clk_sel;
   logic            stat_nxt;
   logic [OE_N-1:0] dat_d;
   logic [OE_N-1:0] dat_q;
   logic [OE_N-1:0] oe_q;
   logic            lockref_q;

   crm_edge_div #(.CODE_W(1)) u_half (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (dly_clk_i),
      .clr_i  (dpa_rst_i),
      .code_i (1'b1),
      .nxt_o  (half_nxt)
   );

   crm_edge_div #(.CODE_W(SCALE_W)) u_scale (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (dly_clk_i),
      .clr_i  (dpa_rst_i),
      .code_i (scale_i),
      .nxt_o  (scl_nxt)
   );

   crm_status_sel u_stat (
      .stat_en_i  (stat_en_i),
      .in_sel_i   (in_sel_i),
      .ref_pol_i  (ref_pol_i),
      .hsync_i    (hsync_i),
      .osc_ref_i  (osc_ref_i),
      .dpa_lock_i (dpa_lock_i),
      .pll_lock_i (pll_lock_i),
      .nxt_o      (stat_nxt)
   );

   assign clk_sel = clk_src_i ? fix_clk_i : half_nxt;

   always_comb begin
      dat_d          = '0;
      dat_d[OE_PDPA] = dly_clk_i;
      dat_d[OE_SDPA] = scl_nxt;
      dat_d[OE_PCLK] = clk_sel;
      dat_d[OE_SCLK] = clk_sel;
      dat_d[OE_FUNC] = func_sel_i ? hsync_i : line_pulse_i;
   end

   for (genvar i = 0; i < OE_N; i++) begin : g_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dat_q[i] <= 1'b0;
            oe_q[i]  <= 1'b1;
         end else begin
            dat_q[i] <= dat_d[i] & oe_en_i[i];
            oe_q[i]  <= oe_en_i[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lockref_q <= 1'b0;
      else        lockref_q <= stat_nxt;
   end

   assign pdpa_o    = dat_q[OE_PDPA];
   assign pdpa_oe_o = oe_q[OE_PDPA];
   assign sdpa_o    = dat_q[OE_SDPA];
   assign sdpa_oe_o = oe_q[OE_SDPA];
   assign pclk_o    = dat_q[OE_PCLK];
   assign pclk_oe_o = oe_q[OE_PCLK];
   assign sclk_o    = dat_q[OE_SCLK];
   assign sclk_oe_o = oe_q[OE_SCLK];
   assign func_o    = dat_q[OE_FUNC];
   assign func_oe_o = oe_q[OE_FUNC];
   assign lockref_o = lockref_q;
endmodule

// File: rtl/crm_checker.sv
module crm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       fix_clk_i,
   input logic       dly_clk_i,
   input logic       line_pulse_i,
   input logic       hsync_i,
   input logic       osc_ref_i,
   input logic       dpa_lock_i,
   input logic       pll_lock_i,
   input logic       dpa_rst_i,
   input logic [4:0] oe_en_i,
   input logic       clk_src_i,
   input logic       func_sel_i,
   input logic [1:0] stat_en_i,
   input logic       in_sel_i,
   input logic       ref_pol_i,
   input logic       pdpa_o,
   input logic       pdpa_oe_o,
   input logic       sdpa_o,
   input logic       sdpa_oe_o,
   input logic       pclk_o,
   input logic       pclk_oe_o,
   input logic       sclk_o,
   input logic       sclk_oe_o,
   input logic       func_o,
   input logic       func_oe_o,
   input logic       lockref_o
);
   assert_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_en_i == 2'b00) |=> !lockref_o);

   assert_dpa_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_en_i == 2'b10) |=> (lockref_o == $past(dpa_lock_i)));

   assert_pll_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_en_i == 2'b01) |=> (lockref_o == $past(pll_lock_i)));

   assert_ref_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_en_i == 2'b11 && !in_sel_i) |=> (lockref_o == $past(hsync_i ^ ref_pol_i)));

   assert_ref_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_en_i == 2'b11 && in_sel_i) |=> (lockref_o == $past(osc_ref_i)));

   assert_full_rate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_src_i && oe_en_i[2]) |=> (pclk_o == $past(fix_clk_i)));

   assert_func_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_en_i[4]) |=> (func_o == $past(func_sel_i ? hsync_i : line_pulse_i)));

   assert_oe_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ({func_oe_o, sclk_oe_o, pclk_oe_o, sdpa_oe_o, pdpa_oe_o} == $past(oe_en_i)));

   assert_hiz_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pdpa_oe_o -> !pdpa_o) && (!sdpa_oe_o -> !sdpa_o) && (!pclk_oe_o -> !pclk_o)
      && (!sclk_oe_o -> !sclk_o) && (!func_oe_o -> !func_o));

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dpa_rst_i |=> !sdpa_o);

   assert_undivided_R10: assert property (@(posedge clk) disable iff (!rst_n)
      oe_en_i[0] |=> (pdpa_o == $past(dly_clk_i)));
endmodule

bind clk_route_mux crm_checker u_chk (.*);

// File: tb/sim_clk_route_mux.sv
module sim_clk_route_mux;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fix_clk_i = 1'b0, dly_clk_i = 1'b0;
   logic       line_pulse_i = 1'b0, hsync_i = 1'b0, osc_ref_i = 1'b0;
   logic       dpa_lock_i = 1'b0, pll_lock_i = 1'b0, dpa_rst_i = 1'b0;
   logic [4:0] oe_en_i = 5'h1F;
   logic       clk_src_i = 1'b0, func_sel_i = 1'b0, in_sel_i = 1'b0, ref_pol_i = 1'b0;
   logic [1:0] stat_en_i = 2'b00;
   logic [1:0] scale_i = 2'd0;
   logic pdpa_o, pdpa_oe_o, sdpa_o, sdpa_oe_o, pclk_o, pclk_oe_o;
   logic sclk_o, sclk_oe_o, func_o, func_oe_o, lockref_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #5 clk = ~clk;

   clk_route_mux #(.SCALE_W(2)) u0 (.*);

   // reference model state
   bit    m_valid = 0;
   bit    m_prev = 0;
   int    n_half = 0, n_scl = 0;
   bit    e_pdpa, e_sdpa, e_pclk, e_sclk, e_func, e_lock;
   bit [4:0] e_oe;
   string lock_req = "R1";

   always @(posedge clk) begin
      bit rise, half_v, scl_v, clkv;
      if (!rst_n) begin
         m_valid = 0; m_prev = 0; n_half = 0; n_scl = 0;
      end else begin
         rise = dly_clk_i && !m_prev;
         if (dpa_rst_i) begin
            n_half = 0; n_scl = 0; half_v = 0; scl_v = 0;
         end else begin
            if (rise) begin n_half++; n_scl++; end
            half_v = n_half[0];
            scl_v  = (scale_i == 0) ? dly_clk_i : bit'((n_scl >> (scale_i - 1)) & 1);
         end
         m_prev = dly_clk_i;
         clkv   = clk_src_i ? fix_clk_i : half_v;
         e_oe   = oe_en_i;
         e_pdpa = oe_en_i[0] & dly_clk_i;
         e_sdpa = oe_en_i[1] & scl_v;
         e_pclk = oe_en_i[2] & clkv;
         e_sclk = oe_en_i[3] & clkv;
         e_func = oe_en_i[4] & (func_sel_i ? hsync_i : line_pulse_i);
         case (stat_en_i)
            2'b00: begin e_lock = 0; lock_req = "R1"; end
            2'b10: begin e_lock = dpa_lock_i; lock_req = "R2"; end
            2'b01: begin e_lock = pll_lock_i; lock_req = "R2"; end
            default: begin
               e_lock = in_sel_i ? osc_ref_i : (hsync_i ^ ref_pol_i);
               lock_req = "R3";
            end
         endcase
         m_valid = 1;
      end
   end

   task automatic chk(input string req, input string name, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual %0b expected %0b", req, name, act, exp);
      end
   endtask

   // every-cycle comparison; one-cycle latency on all paths (R11)
   always @(negedge clk) begin
      if (rst_n && m_valid && !done) begin
         chk("R10", "pdpa_o", pdpa_o, e_pdpa);
         chk("R4",  "sdpa_o", sdpa_o, e_sdpa);
         chk("R5",  "pclk_o", pclk_o, e_pclk);
         chk("R5",  "sclk_o", sclk_o, e_sclk);
         chk("R6",  "func_o", func_o, e_func);
         chk(lock_req, "lockref_o", lockref_o, e_lock);
         chk("R7",  "oe_vec",
             ({func_oe_o, sclk_oe_o, pclk_oe_o, sdpa_oe_o, pdpa_oe_o} == e_oe), 1'b1);
      end
   end

   // waveform sources: delayed clock period 6, fixed clock period 4
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         ph++;
         dly_clk_i = ((ph % 6) < 3);
         fix_clk_i = ((ph % 4) < 2);
      end
   end

   task automatic finish_run();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      int cyc = 0;
      repeat (3) @(negedge clk);
      // R8: reset values
      chk("R8", "reset oe", ({func_oe_o, sclk_oe_o, pclk_oe_o, sdpa_oe_o, pdpa_oe_o} == 5'h1F), 1'b1);
      chk("R8", "reset data", (|{pdpa_o, sdpa_o, pclk_o, sclk_o, func_o, lockref_o}), 1'b0);
      rst_n = 1'b1;
      for (int sc = 0; sc < 4; sc++) begin
         for (int src = 0; src < 2; src++) begin
            for (int md = 0; md < 4; md++) begin
               for (int is = 0; is < 2; is++) begin
                  scale_i   = 2'(sc);
                  clk_src_i = src[0];
                  stat_en_i = 2'(md);
                  in_sel_i  = is[0];
                  oe_en_i   = (sc >= 2) ? 5'($urandom) : 5'h1F;
                  for (int k = 0; k < 6; k++) begin
                     @(negedge clk);
                     cyc++;
                     hsync_i      = 1'($urandom);
                     line_pulse_i = 1'($urandom);
                     osc_ref_i    = 1'($urandom);
                     dpa_lock_i   = 1'($urandom);
                     pll_lock_i   = 1'($urandom);
                     ref_pol_i    = 1'($urandom);
                     func_sel_i   = 1'($urandom);
                     dpa_rst_i    = (cyc % 50 == 0);
                  end
               end
            end
         end
      end
      // R9: directed clear, then counting restarts
      @(negedge clk);
      dpa_rst_i = 0; oe_en_i = 5'h1F; scale_i = 2'd3; clk_src_i = 0;
      repeat (20) @(negedge clk);
      dpa_rst_i = 1;
      @(negedge clk);
      dpa_rst_i = 0;
      chk("R9", "sdpa after clear", sdpa_o, 1'b0);
      chk("R9", "half clk after clear", pclk_o, 1'b0);
      repeat (60) @(negedge clk);
      // R7: all disabled
      oe_en_i = 5'h00;
      repeat (2) @(negedge clk);
      chk("R7", "all hiz", (|{pdpa_oe_o, sdpa_oe_o, pclk_oe_o, sclk_oe_o, func_oe_o}), 1'b0);
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule